// File: doc/BRIEF.md
# Supply Monitor Input Qualifier

This block sits in front of a power sequencer. It watches a set of rail comparator outputs (one bit per rail, high while the rail sits above its undervoltage threshold), an enable input of configurable polarity, and a shared open-drain system-reset line. Every rail bit and the enable are synchronised and deglitched, so a dip shorter than the filter window never reaches the sequencer. When every rail and the enable are qualified, the block reports all-good and stops pulling the shared line low. It then times a stabilisation lockout before it raises a start request.

The shared line is a wired-AND. The block pulls it low while anything is unqualified. Other devices on the bus can hold it low as well. If another device holds the line low after this block has let go, the line's later rise starts the sequencer at once and skips the lockout. A qualified rail that drops produces a one-cycle fault pulse. Dropping the enable is a normal shutdown: it withdraws all-good and the start request but raises no fault. All windows are given in time units and converted to clock cycles from a clock-frequency parameter.

Top module: `supply_qualifier`

## Requirements
- R1: While reset is held and in the cycle after it, all_good_o=0, start_req_o=0, fault_o=0 and srst_pull_low_o=1.
- R2: A rail bit (1 = rail good) takes a new value only after it has held that value for FILTER_NS worth of clock cycles in a row. Shorter excursions leave all_good_o unchanged.
- R3: all_good_o is 1 exactly when every filtered rail bit and the filtered enable are good. srst_pull_low_o is its inverse, with no lockout wait.
- R4: With EN_ACTIVE_HIGH=1 a high enable_i asserts enable. With EN_ACTIVE_HIGH=0 a low enable_i asserts it.
- R5: enable_i passes through the same deglitch filter as the rails. A short enable pulse has no effect on all_good_o.
- R6: start_req_o rises only after all_good_o and a high shared line have been held together for LOCKOUT_US worth of clock cycles. Once risen, it stays high while both conditions stay true.
- R7: If all_good_o or the line is lost before start_req_o rises, the lockout count restarts from zero.
- R8: If the shared line is held low by another device after this block has released it, the line's rise while all_good_o=1 raises start_req_o within a few cycles, without the lockout.
- R9: When a qualified rail drops (after filtering), fault_o pulses high for one cycle and start_req_o returns to 0.
- R10: Dropping the enable clears all_good_o and start_req_o without any fault_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rail_ok_i | input | NUM_RAILS | Comparator outputs, 1 = rail above threshold |
| enable_i | input | 1 | Enable request, polarity set by EN_ACTIVE_HIGH |
| srst_line_i | input | 1 | Sampled level of the shared open-drain reset line |
| srst_pull_low_o | output | 1 | 1 = drive the shared line low |
| all_good_o | output | 1 | All rails and enable qualified |
| fault_o | output | 1 | One-cycle pulse when a qualified rail drops |
| start_req_o | output | 1 | Start request to the sequencer (level) |

## Verification
The embedded assertions check three things on every cycle. A filtered bit changes only at the end of a full hold window. The lockout counter stays in range. A start request that did not come from the bypass rises only from a full count. Fault pulses are also checked against a low all-good.

Other behaviour needs the bench's scenarios to show it. These are the exact stimulus lengths that count as glitches, the active-low enable variant, and the restart of the lockout after a brief loss. The bench also covers the external bypass through a modelled wired-AND line and the absence of a fault on a plain enable shutdown.

// File: rtl/sq_pkg.sv
package sq_pkg;

   typedef enum logic [1:0] {
      LK_IDLE  = 2'd0,
      LK_COUNT = 2'd1,
      LK_DONE  = 2'd2
   } lk_state_e;

   function automatic int unsigned ns_to_cycles(input longint unsigned hz,
                                                input longint unsigned ns);
      return int'((hz * ns) / 64'd1_000_000_000);
   endfunction

   function automatic int unsigned us_to_cycles(input longint unsigned hz,
                                                input longint unsigned us);
      return int'((hz * us) / 64'd1_000_000);
   endfunction

endpackage

// File: rtl/sq_deglitch.sv
module sq_deglitch #(
   parameter int unsigned HOLD_CYC = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic clean_o
);
   localparam int unsigned CW = $clog2(HOLD_CYC + 1);

   generate
      if (HOLD_CYC < 2) begin : g_bad_hold
         $error("sq_deglitch: HOLD_CYC must be at least 2");
      end
   endgenerate

   logic [1:0]    sync_q;
   logic [CW-1:0] cnt_q;
   logic          clean_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q  <= '0;
         cnt_q   <= '0;
         clean_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[0], raw_i};
         if (sync_q[1] == clean_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(HOLD_CYC - 1)) begin
            clean_q <= sync_q[1];
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign clean_o = clean_q;

   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(HOLD_CYC));

   assert_change_needs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clean_q != $past(clean_q)) |-> ($past(cnt_q) == CW'(HOLD_CYC - 1)));

endmodule

// File: rtl/sq_lockout.sv
module sq_lockout
   import sq_pkg::*;
#(
   parameter int unsigned LOCK_CYC = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond_i,
   input  logic line_i,
   output logic start_o
);
   localparam int unsigned LW = $clog2(LOCK_CYC + 1);

   generate
      if (LOCK_CYC < 2) begin : g_bad_lock
         $error("sq_lockout: LOCK_CYC must be at least 2");
      end
   endgenerate

   logic [1:0]    line_sync_q;
   logic          line_prev_q;
   logic [1:0]    rel_age_q;
   logic          ext_low_q;
   logic [LW-1:0] cnt_q;
   lk_state_e     state_q;
   logic          line_hi;
   logic          qual;
   logic          bypass;

   assign line_hi = line_sync_q[1];
   assign qual    = cond_i && line_hi;
   assign bypass  = qual && !line_prev_q && ext_low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_sync_q <= '0;
         line_prev_q <= 1'b0;
         rel_age_q   <= '0;
         ext_low_q   <= 1'b0;
      end else begin
         line_sync_q <= {line_sync_q[0], line_i};
         line_prev_q <= line_hi;
         if (!cond_i) begin
            rel_age_q <= '0;
         end else if (rel_age_q != 2'd3) begin
            rel_age_q <= rel_age_q + 1'b1;
         end
         ext_low_q <= cond_i && (rel_age_q == 2'd3) && !line_hi;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LK_IDLE;
         cnt_q   <= '0;
      end else if (!qual) begin
         state_q <= LK_IDLE;
         cnt_q   <= '0;
      end else if (bypass) begin
         state_q <= LK_DONE;
      end else if (state_q != LK_DONE) begin
         if (cnt_q == LW'(LOCK_CYC - 1)) begin
            state_q <= LK_DONE;
         end else begin
            state_q <= LK_COUNT;
            cnt_q   <= cnt_q + 1'b1;
         end
      end
   end

   assign start_o = (state_q == LK_DONE);

   assert_lock_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < LW'(LOCK_CYC));

   assert_start_needs_qual_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_o) |-> $past(qual));

   assert_full_lockout_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(start_o) && !$past(bypass)) |-> ($past(cnt_q) == LW'(LOCK_CYC - 1)));

endmodule

// File: rtl/supply_qualifier.sv
module supply_qualifier
   import sq_pkg::*;
#(
   parameter int unsigned NUM_RAILS      = 4,
   parameter int unsigned CLK_HZ         = 1_000_000,
   parameter int unsigned FILTER_NS      = 7000,
   parameter int unsigned LOCKOUT_US     = 10000,
   parameter bit          EN_ACTIVE_HIGH = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_RAILS-1:0] rail_ok_i,
   input  logic                 enable_i,
   input  logic                 srst_line_i,
   output logic                 srst_pull_low_o,
   output logic                 all_good_o,
   output logic                 fault_o,
   output logic                 start_req_o
);
   localparam int unsigned FILT_CYC = ns_to_cycles(CLK_HZ, FILTER_NS);
   localparam int unsigned LOCK_CYC = us_to_cycles(CLK_HZ, LOCKOUT_US);

   generate
      if (NUM_RAILS < 1) begin : g_bad_rails
         $error("supply_qualifier: NUM_RAILS must be at least 1");
      end
   endgenerate

   logic [NUM_RAILS-1:0] rail_clean;
   logic [NUM_RAILS-1:0] rail_prev_q;
   logic                 en_norm;
   logic                 en_clean;
   logic                 fault_q;
   logic                 all_good;

   generate
      for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
         sq_deglitch #(.HOLD_CYC(FILT_CYC)) u_rail_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (rail_ok_i[i]),
            .clean_o (rail_clean[i])
         );
      end

      if (EN_ACTIVE_HIGH) begin : g_en_high
         assign en_norm = enable_i;
      end else begin : g_en_low
         assign en_norm = ~enable_i;
      end
   endgenerate

   sq_deglitch #(.HOLD_CYC(FILT_CYC)) u_en_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (en_norm),
      .clean_o (en_clean)
   );

   assign all_good = (&rail_clean) && en_clean;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rail_prev_q <= '0;
         fault_q     <= 1'b0;
      end else begin
         rail_prev_q <= rail_clean;
         fault_q     <= |(rail_prev_q & ~rail_clean);
      end
   end

   sq_lockout #(.LOCK_CYC(LOCK_CYC)) u_lockout (
      .clk     (clk),
      .rst_n   (rst_n),
      .cond_i  (all_good),
      .line_i  (srst_line_i),
      .start_o (start_req_o)
   );

   assign all_good_o      = all_good;
   assign srst_pull_low_o = ~all_good;
   assign fault_o         = fault_q;

   assert_fault_means_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> !all_good_o);

endmodule

// File: tb/supply_qualifier_bench.sv
module supply_qualifier_bench;
   localparam int CLK_PERIOD = 10;
   localparam int FILT       = 7;
   localparam int LOCK       = 100;
   localparam int NVEC       = 12;

   // {rails[13:10], enable[9], hold cycles[8:1], expected all_good[0]}
   localparam logic [13:0] VEC [NVEC] = '{
      {4'hF, 1'b1, 8'd12, 1'b1},
      {4'hE, 1'b1, 8'd12, 1'b0},
      {4'hF, 1'b1, 8'd12, 1'b1},
      {4'hB, 1'b1, 8'd4,  1'b1},
      {4'hF, 1'b1, 8'd12, 1'b1},
      {4'hF, 1'b0, 8'd4,  1'b1},
      {4'hF, 1'b0, 8'd12, 1'b0},
      {4'h7, 1'b1, 8'd12, 1'b0},
      {4'h0, 1'b1, 8'd12, 1'b0},
      {4'hF, 1'b1, 8'd12, 1'b1},
      {4'hD, 1'b1, 8'd6,  1'b1},
      {4'hF, 1'b1, 8'd12, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] rails = 4'h0;
   logic       en = 1'b0;
   logic       en_lo = 1'b1;
   logic       ext_low = 1'b0;
   logic       pull_low, all_good, fault, start_req;
   logic       pull_low_n, all_good_n, fault_n, start_req_n;
   logic       line, line_n;
   int         n_chk = 0;
   int         n_fail = 0;

   assign line   = !(pull_low || ext_low);
   assign line_n = !pull_low_n;

   always #(CLK_PERIOD / 2) clk = ~clk;

   supply_qualifier #(.NUM_RAILS(4), .CLK_HZ(1_000_000), .FILTER_NS(7000),
                      .LOCKOUT_US(100), .EN_ACTIVE_HIGH(1'b1)) u_supply_qualifier (
      .clk(clk), .rst_n(rst_n), .rail_ok_i(rails), .enable_i(en),
      .srst_line_i(line), .srst_pull_low_o(pull_low), .all_good_o(all_good),
      .fault_o(fault), .start_req_o(start_req));

   supply_qualifier #(.NUM_RAILS(4), .CLK_HZ(1_000_000), .FILTER_NS(7000),
                      .LOCKOUT_US(100), .EN_ACTIVE_HIGH(1'b0)) u_supply_qualifier_lo (
      .clk(clk), .rst_n(rst_n), .rail_ok_i(rails), .enable_i(en_lo),
      .srst_line_i(line_n), .srst_pull_low_o(pull_low_n), .all_good_o(all_good_n),
      .fault_o(fault_n), .start_req_o(start_req_n));

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      int faults;
      step(3);
      // R1 reset state
      chk("R1 all_good", all_good, 1'b0);
      chk("R1 start_req", start_req, 1'b0);
      chk("R1 fault", fault, 1'b0);
      chk("R1 pull_low", pull_low, 1'b1);
      rst_n = 1'b1;
      step(1);
      chk("R1 pull_low after reset", pull_low, 1'b1);

      // Table walk: R2 rail glitches, R3 combination, R5 enable glitch
      for (int i = 0; i < NVEC; i++) begin
         rails = VEC[i][13:10];
         en    = VEC[i][9];
         step(int'(VEC[i][8:1]));
         chk("R2/R3/R5 all_good", all_good, VEC[i][0]);
         chk("R3 pull_low", pull_low, ~VEC[i][0]);
      end
      chk("R4 active-low idle", all_good_n, 1'b0);

      // R4 active-low enable variant
      en_lo = 1'b0;
      step(12);
      chk("R4 active-low asserted", all_good_n, 1'b1);
      en_lo = 1'b1;
      step(12);
      chk("R4 active-low released", all_good_n, 1'b0);

      // R6 full lockout
      en = 1'b0;
      step(12);
      chk("R10 start cleared", start_req, 1'b0);
      en = 1'b1;
      step(12);
      chk("R3 released before lockout", pull_low, 1'b0);
      chk("R6 no early start", start_req, 1'b0);
      step(LOCK - 10);
      chk("R6 start not before lockout", start_req, 1'b0);
      step(13);
      chk("R6 start after lockout", start_req, 1'b1);

      // R7 restart on brief loss
      en = 1'b0;
      step(12);
      en = 1'b1;
      step(12 + LOCK / 2);
      en = 1'b0;
      step(12);
      chk("R7 enable loss seen", all_good, 1'b0);
      en = 1'b1;
      step(LOCK + 2);
      chk("R7 count restarted", start_req, 1'b0);
      step(13);
      chk("R7 start after fresh count", start_req, 1'b1);

      // R8 external hold then release bypasses lockout
      en = 1'b0;
      step(12);
      ext_low = 1'b1;
      en = 1'b1;
      step(LOCK / 2);
      chk("R8 qualified while held", all_good, 1'b1);
      chk("R8 no start while held", start_req, 1'b0);
      ext_low = 1'b0;
      step(6);
      chk("R8 bypass start", start_req, 1'b1);

      // R9 rail drop gives one fault pulse
      faults = 0;
      rails = 4'hB;
      for (int c = 0; c < 16; c++) begin
         step(1);
         if (fault) faults++;
      end
      chk("R9 single fault pulse", faults == 1, 1'b1);
      chk("R9 start cleared", start_req, 1'b0);

      // R10 enable drop: no fault
      rails = 4'hF;
      step(LOCK + 20);
      chk("R10 start before disable", start_req, 1'b1);
      faults = 0;
      en = 1'b0;
      for (int c = 0; c < 16; c++) begin
         step(1);
         if (fault) faults++;
      end
      chk("R10 no fault on disable", faults == 0, 1'b1);
      chk("R10 start cleared", start_req, 1'b0);
      chk("R10 all_good cleared", all_good, 1'b0);

      finish_run();
   end
endmodule